// File: doc/BRIEF.md
# Power-Up Configuration Loader

This block fills a device's trim and control registers from non-volatile memory each time reset is released, so the part comes up configured without any host traffic. Right after reset it walks a fixed 32-byte window of the memory, starting at address 8100h. It reads one byte per cycle from a read port with a one-cycle latency. The first 28 returned bytes go to register addresses 00h to 1Bh. The next byte is an optional CRC8 check value. The last three bytes are read and then discarded.

While the copy runs, the loader owns the register-file write port and turns away any host write. Once the copy finishes, a done flag rises and stays high until the next reset. From then on, host writes pass straight through to the register file, so software can overwrite any register the loader set. When the check value does not match the CRC computed over the copied bytes, an error flag is raised. The loaded registers are kept in either case.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is high, `load_done` and `crc_err` are 0. In the first cycle after reset falls, `mem_rd_en` is 1 and `mem_addr` is 8100h.
- R2: The loader issues exactly 32 reads, one per cycle, at consecutive addresses 8100h through 811Fh. It issues no further reads until the next reset.
- R3: The byte returned for block offset i (0 to 27) is written to register address i. The write happens in the cycle after that byte's read is issued.
- R4: Bytes at block offsets 28 to 31 are never written to the register file. During the load, no register address above 1Bh is written.
- R5: `load_done` rises on the 33rd rising clock edge after reset is released, which is one cycle after the last byte is captured. It then stays high until reset.
- R6: A host write presented while the load is running is refused. `host_refused` is 1 in that cycle, and the write never reaches the register file.
- R7: After `load_done` is high, a host write appears on the register-file write port in the same cycle, with its address and data unchanged, and `host_refused` is 0.
- R8: The byte at block offset 28 is compared with a CRC8 of offsets 0 to 27. The CRC uses polynomial 07h, initial value 00h, MSB first, with no final XOR. On a mismatch, `crc_err` becomes 1 and stays 1 until reset, and the copied registers are kept.
- R9: A later reset clears `load_done` and `crc_err` and runs the whole load again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the strobe |
| host_wr_en | input | 1 | Host register write request |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host register write data |
| host_refused | output | 1 | Host write turned away because the load is running |
| reg_wr_en | output | 1 | Register-file write enable |
| reg_addr | output | 8 | Register-file write address |
| reg_wdata | output | 8 | Register-file write data |
| load_done | output | 1 | Load complete; sticky until reset |
| crc_err | output | 1 | Check value mismatch; sticky until reset |

## Verification
The bench targets the following corner cases. Each is listed with what a design that got it wrong would do.
- **Capture alignment.** The bench runs the load over several memory contents and compares all 28 registers byte by byte. A capture that is off by one cycle would shift every register by one address. It would also push the check byte into register 1Bh.
- **Tail of the window.** A window that is too long or too short changes the read count and the done cycle. Writing the tail bytes would overwrite registers above 1Bh, which the bench preloads with a marker value.
- **Arbitration edges.** The bench sends host writes both during the load and just after it ends. This exposes a loader that leaks host writes into the register file, or one that keeps refusing them after completion.
- **Check byte.** Runs with a good check byte and a corrupted one verify the CRC polynomial and the comparison offset. They also verify that the error flag is cleared by the next reset.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned MEM_AW    = 16;
    localparam int unsigned REG_AW    = 8;
    localparam int unsigned IDX_W     = 8;

    localparam logic [MEM_AW-1:0] SRC_BASE_DEF  = 16'h8100;
    localparam int unsigned       BLOCK_LEN_DEF = 32;
    localparam int unsigned       REG_COUNT_DEF = 28;
    localparam logic [DATA_W-1:0] CRC_POLY      = 8'h07;

    typedef enum logic [1:0] {
        LD_ISSUE = 2'd0,
        LD_DRAIN = 2'd1,
        LD_IDLE  = 2'd2
    } ld_state_e;

    // byte returned by the memory, tagged with its block offset
    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } cap_t;

    // one write on the register-file port
    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    // MSB-first CRC8 step over one byte
    function automatic logic [DATA_W-1:0] crc8_update(input logic [DATA_W-1:0] crc,
                                                      input logic [DATA_W-1:0] din);
        logic [DATA_W-1:0] c;
        c = crc ^ din;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
    import cfg_boot_pkg::*;
#(
    parameter logic [MEM_AW-1:0] SRC_BASE  = SRC_BASE_DEF,
    parameter int unsigned       BLOCK_LEN = BLOCK_LEN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rd_en,
    output logic [MEM_AW-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output cap_t              cap,
    output logic              busy,
    output logic              done
);

    localparam int unsigned       CNT_W    = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(BLOCK_LEN - 1);
    localparam logic [MEM_AW-1:0] LAST_ADR = SRC_BASE + MEM_AW'(BLOCK_LEN - 1);

    ld_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              cap_vld_q;
    logic [IDX_W-1:0]  cap_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LD_ISSUE;
            cnt_q     <= '0;
            cap_vld_q <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_vld_q <= rd_en;
            cap_idx_q <= IDX_W'(cnt_q);
            case (state_q)
                LD_ISSUE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_CNT) state_q <= LD_DRAIN;
                end
                LD_DRAIN: state_q <= LD_IDLE;
                default:  state_q <= LD_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_en     = !rst && (state_q == LD_ISSUE);
        rd_addr   = SRC_BASE + MEM_AW'(cnt_q);
        busy      = (state_q != LD_IDLE);
        done      = (state_q == LD_IDLE);
        cap.valid = cap_vld_q;
        cap.idx   = cap_idx_q;
        cap.data  = rd_data;
    end

    // R2: reads stay inside the source window
    a_r2_addr_window: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr >= SRC_BASE && rd_addr <= LAST_ADR));

    // R2: back-to-back reads step by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 1'b1);

    // R2: nothing is read once the load has finished
    a_r2_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_en);

    // R3: a captured byte always follows an issued read
    a_r3_capture_after_read: assert property (@(posedge clk) disable iff (rst)
        cap.valid |-> $past(rd_en));

    // R5: completion is sticky
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

endmodule

// File: rtl/cfg_boot_crc.sv
module cfg_boot_crc
    import cfg_boot_pkg::*;
#(
    parameter int unsigned REG_COUNT = REG_COUNT_DEF,
    parameter int unsigned CRC_OFS   = REG_COUNT_DEF,
    parameter bit          CRC_EN    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  cap_t cap,
    output logic crc_err
);

    localparam logic [IDX_W-1:0] REG_LIM = IDX_W'(REG_COUNT);
    localparam logic [IDX_W-1:0] CHK_IDX = IDX_W'(CRC_OFS);

    generate
        if (CRC_EN) begin : g_crc
            logic [DATA_W-1:0] crc_q;
            logic              err_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    crc_q <= '0;
                    err_q <= 1'b0;
                end else if (cap.valid) begin
                    if (cap.idx < REG_LIM) crc_q <= crc8_update(crc_q, cap.data);
                    if (cap.idx == CHK_IDX && cap.data != crc_q) err_q <= 1'b1;
                end
            end

            assign crc_err = err_q;

            // R8: a mismatch stays flagged until reset
            a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
                crc_err |=> crc_err);
        end else begin : g_nocrc
            assign crc_err = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cfg_boot_arb.sv
module cfg_boot_arb
    import cfg_boot_pkg::*;
#(
    parameter int unsigned REG_COUNT = REG_COUNT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  cap_t              cap,
    input  logic              host_wr_en,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output reg_wr_t           wr,
    output logic              host_refused
);

    localparam logic [IDX_W-1:0]  REG_LIM  = IDX_W'(REG_COUNT);
    localparam logic [REG_AW-1:0] ADDR_LIM = REG_AW'(REG_COUNT);

    reg_wr_t ldr_wr;
    reg_wr_t hst_wr;

    always_comb begin
        ldr_wr.we   = cap.valid && (cap.idx < REG_LIM);
        ldr_wr.addr = REG_AW'(cap.idx);
        ldr_wr.data = cap.data;

        hst_wr.we   = host_wr_en;
        hst_wr.addr = host_addr;
        hst_wr.data = host_wdata;

        if (busy) begin
            wr           = ldr_wr;
            host_refused = host_wr_en;
        end else begin
            wr           = hst_wr;
            host_refused = 1'b0;
        end
    end

    // R4: the loader never writes past the last configuration register
    a_r4_loader_range: assert property (@(posedge clk) disable iff (rst)
        busy && wr.we |-> wr.addr < ADDR_LIM);

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
    import cfg_boot_pkg::*;
#(
    parameter logic [MEM_AW-1:0] SRC_BASE  = SRC_BASE_DEF,
    parameter int unsigned       BLOCK_LEN = BLOCK_LEN_DEF,
    parameter int unsigned       REG_COUNT = REG_COUNT_DEF,
    parameter bit                CRC_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              host_wr_en,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_refused,
    output logic              reg_wr_en,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              load_done,
    output logic              crc_err
);

    localparam int unsigned CRC_OFS = REG_COUNT;

    cap_t    cap;
    reg_wr_t wr;
    logic    busy;

    cfg_boot_seq #(.SRC_BASE(SRC_BASE), .BLOCK_LEN(BLOCK_LEN)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (mem_rd_en),
        .rd_addr (mem_addr),
        .rd_data (mem_rdata),
        .cap     (cap),
        .busy    (busy),
        .done    (load_done)
    );

    cfg_boot_crc #(.REG_COUNT(REG_COUNT), .CRC_OFS(CRC_OFS), .CRC_EN(CRC_EN)) crc_i (
        .clk     (clk),
        .rst     (rst),
        .cap     (cap),
        .crc_err (crc_err)
    );

    cfg_boot_arb #(.REG_COUNT(REG_COUNT)) arb_i (
        .clk          (clk),
        .rst          (rst),
        .busy         (busy),
        .cap          (cap),
        .host_wr_en   (host_wr_en),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .wr           (wr),
        .host_refused (host_refused)
    );

    assign reg_wr_en = wr.we;
    assign reg_addr  = wr.addr;
    assign reg_wdata = wr.data;

    // R6: refusals only happen before completion
    a_r6_refuse_only_loading: assert property (@(posedge clk) disable iff (rst)
        host_refused |-> !load_done);

endmodule

// File: tb/cfg_boot_loader_tb.sv
module cfg_boot_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [7:0]  host_wdata = 8'h00;
    logic        host_refused;
    logic        reg_wr_en;
    logic [7:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic        load_done;
    logic        crc_err;

    always #10 clk = ~clk;

    cfg_boot_loader dut_i (
        .clk(clk), .rst(rst),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_refused(host_refused),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .load_done(load_done), .crc_err(crc_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cur_seed = 0;
    bit cur_good = 1'b1;
    int rd_cnt = 0;
    int addr_err = 0;
    int hi_wr = 0;
    logic [7:0] rf [256];

    function automatic logic [7:0] data_byte(int seed, int off);
        return 8'((off * 29 + seed * 53 + 7) ^ (seed * 3));
    endfunction

    function automatic logic [7:0] ref_crc(int seed);
        logic [15:0] r;
        r = 16'h0;
        for (int i = 0; i < 28; i++) begin
            r[15:8] = r[15:8] ^ data_byte(seed, i);
            for (int k = 0; k < 8; k++) begin
                if (r[15]) r = (r << 1) ^ 16'h0700;
                else       r = r << 1;
            end
        end
        return r[15:8];
    endfunction

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        int off;
        off = int'(a) - 32'h8100;
        if (off < 0 || off > 31) return 8'hFF;
        if (off == 28) return cur_good ? ref_crc(cur_seed) : (ref_crc(cur_seed) ^ 8'h5A);
        return data_byte(cur_seed, off);
    endfunction

    // memory with one-cycle read latency, plus address-order monitor
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem_byte(mem_addr);
            if (mem_addr != 16'(32'h8100 + rd_cnt)) addr_err = addr_err + 1;
            rd_cnt = rd_cnt + 1;
        end
    end

    // register file model
    always @(posedge clk) begin
        if (reg_wr_en) begin
            rf[reg_addr] <= reg_wdata;
            if (!load_done && reg_addr > 8'h1B) hi_wr = hi_wr + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_load(input int seed, input bit good, input bit prev_bad);
        int cyc;
        @(negedge clk);
        rst = 1'b1;
        cur_seed = seed;
        cur_good = good;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 256; i++) rf[i] = 8'hEE;
        rd_cnt = 0;
        addr_err = 0;
        hi_wr = 0;
        chk(load_done == 1'b0, "R1 done low in reset", int'(load_done), 0);
        if (prev_bad) chk(crc_err == 1'b0, "R9 crc_err cleared by reset", int'(crc_err), 0);
        else          chk(crc_err == 1'b0, "R1 crc_err low in reset", int'(crc_err), 0);
        rst = 1'b0;
        #1;
        chk(mem_rd_en == 1'b1, "R1 first read strobe", int'(mem_rd_en), 1);
        chk(mem_addr == 16'h8100, "R1 first read address", int'(mem_addr), 32'h8100);
        cyc = 0;
        while (!load_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (cyc == 10) begin
                host_wr_en = 1'b1; host_addr = 8'h05; host_wdata = 8'hC3;
                #1;
                chk(host_refused == 1'b1, "R6 refused while loading", int'(host_refused), 1);
            end else if (cyc == 12) begin
                host_wr_en = 1'b1; host_addr = 8'h1E; host_wdata = 8'h11;
            end else begin
                host_wr_en = 1'b0;
            end
        end
        host_wr_en = 1'b0;
        chk(cyc == 33, "R5 done timing", cyc, 33);
        chk(rd_cnt == 32, "R2 read count", rd_cnt, 32);
        chk(addr_err == 0, "R2 read address order", addr_err, 0);
        for (int i = 0; i < 28; i++)
            chk(rf[i] == data_byte(seed, i), "R3 register content", int'(rf[i]), int'(data_byte(seed, i)));
        for (int i = 28; i < 256; i++)
            chk(rf[i] == 8'hEE, "R4 register untouched", int'(rf[i]), 32'hEE);
        chk(hi_wr == 0, "R4 no high write during load", hi_wr, 0);
        chk(rf[5] == data_byte(seed, 5), "R6 refused write dropped", int'(rf[5]), int'(data_byte(seed, 5)));
        chk(crc_err == !good, "R8 crc flag", int'(crc_err), int'(!good));
        repeat (5) @(negedge clk);
        chk(load_done == 1'b1, "R5 done stays high", int'(load_done), 1);
        chk(rd_cnt == 32, "R2 no reads after done", rd_cnt, 32);
        chk(crc_err == !good, "R8 crc flag held", int'(crc_err), int'(!good));
        host_wr_en = 1'b1; host_addr = 8'h03; host_wdata = 8'(seed + 8'h40);
        #1;
        chk(reg_wr_en == 1'b1 && reg_addr == 8'h03 && reg_wdata == 8'(seed + 8'h40),
            "R7 host write passes", int'({reg_wr_en, reg_addr, reg_wdata}),
            int'({1'b1, 8'h03, 8'(seed + 8'h40)}));
        chk(host_refused == 1'b0, "R7 not refused after done", int'(host_refused), 0);
        @(negedge clk);
        host_wr_en = 1'b0;
        chk(rf[3] == 8'(seed + 8'h40), "R7 host value stored", int'(rf[3]), int'(8'(seed + 8'h40)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit prev_bad;
        prev_bad = 1'b0;
        for (int s = 0; s < 6; s++) begin
            run_load(s * 7 + 1, (s % 2) == 0, prev_bad);
            prev_bad = (s % 2) != 0;
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule